// File: doc/BRIEF.md
# Cascadable Active-Low Priority Encoder

This block turns a bank of request lines into the binary number of the highest-numbered line that is asking for service. Requests and the enable are active low. The block is built from identical 8-line encoder stages. Each stage produces a complemented 3-bit index and two handshake flags: a group flag, low when the stage is enabled and has a request, and a pass-down flag, low when the stage is enabled but has nothing to report. The pass-down flag of each stage enables the stage below it. The stages are therefore chained from the top. A stage that holds a request disables every stage beneath it, and the priority order across the whole bank is kept.

The top level chains two stages into a 16-line encoder. The complemented index bits of all stages are merged with a negative-OR, which yields the low three bits in true binary. The position of the stage whose group flag is low supplies the upper code bit. All results are registered once, and a synchronous active-high reset clears them, so the block fits a pipelined FPGA datapath. A request on line 0 and an idle bank both read code 0. The group flag tells the two cases apart.

Top module: `prio_enc_cascade`

## Requirements
- R1: The block takes 16 request lines `req_n`. Line i requests service when `req_n[i]` is 0. The block is enabled when `en_n` is 0.
- R2: When the block is enabled and one or more lines request, `code` equals the index of the highest-numbered requesting line, as active-high 4-bit binary.
- R3: When `en_n` is 1, the outputs are `code`=0, `gs_n`=1 and `eo_n`=1, whatever `req_n` holds.
- R4: When the block is enabled and no line requests, the outputs are `eo_n`=0, `gs_n`=1 and `code`=0.
- R5: When the block is enabled and at least one line requests, the outputs are `gs_n`=0 and `eo_n`=1.
- R6: Any request on lines 8 to 15 masks every request on lines 0 to 7.
- R7: `code[3]` is 1 exactly when the winning line lies in 8 to 15. `code[2:0]` holds the winner's position within its group of eight.
- R8: A lone request on line 0 gives `code`=0 with `gs_n`=0, which differs from the idle result in R4.
- R9: Each output shows the result of the inputs sampled at a rising clock edge, starting at that edge, and holds it until the next edge.
- R10: A synchronous active-high `rst` sets `code`=0, `gs_n`=1 and `eo_n`=1 at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_n | input | 1 | Enable, active low |
| req_n | input | 16 | Request lines, active low |
| code | output | 4 | Registered index of the winning line, active high |
| gs_n | output | 1 | Registered group flag: low when enabled with at least one request |
| eo_n | output | 1 | Registered pass-down flag: low when enabled with no request |

## Verification
Every result is due one rising edge after its inputs are applied. The bench drives inputs on the falling edge and samples 1 ns after the following rising edge, so each check sees exactly the register stage that captured that stimulus. One scenario also samples just before that edge, to confirm that the previous result is still held there and that the update does not arrive early. The expected values come from a priority scan written in the bench. It covers all 256 patterns of each group of eight under both enable levels, every single line, and the cases where requests cross between the groups.

// File: rtl/pe_pkg.sv
package pe_pkg;
  // Default geometry: stages of 2**PE_STAGE_BITS lines, PE_STAGE_COUNT stages
  localparam int PE_STAGE_BITS  = 3;
  localparam int PE_STAGE_COUNT = 2;

  // Reset / idle levels of the registered handshake flags
  localparam logic PE_FLAG_IDLE = 1'b1;
endpackage

// File: rtl/pe_stage.sv
// One encoder stage: active-low requests, highest index wins,
// complemented index out, group and pass-down flags active low.
module pe_stage #(
  parameter int IDX_W = 3,
  localparam int LINES = 1 << IDX_W
) (
  input  logic [LINES-1:0] req_n,
  input  logic             en_n,
  output logic [IDX_W-1:0] code_n,
  output logic             gs_n,
  output logic             eo_n
);
  logic             any_req;
  logic [IDX_W-1:0] win_idx;

  always_comb begin
    any_req = ~&req_n;
    win_idx = '0;
    // ascending scan: the last hit is the highest index
    for (int i = 0; i < LINES; i++) begin
      if (!req_n[i]) win_idx = IDX_W'(i);
    end
  end

  always_comb begin
    if (en_n) begin
      code_n = '1;
      gs_n   = 1'b1;
      eo_n   = 1'b1;
    end else if (any_req) begin
      code_n = ~win_idx;
      gs_n   = 1'b0;
      eo_n   = 1'b1;
    end else begin
      code_n = '1;
      gs_n   = 1'b1;
      eo_n   = 1'b0;
    end
  end
endmodule

// File: rtl/pe_merge.sv
// Joins the stage outputs: negative-OR of the complemented index bits,
// stage position of the active group flag as the upper code bits.
module pe_merge #(
  parameter int IDX_W  = 3,
  parameter int STAGES = 2,
  localparam int HI_W  = $clog2(STAGES)
) (
  input  logic [STAGES*IDX_W-1:0] code_n_all,
  input  logic [STAGES-1:0]       gs_n_all,
  output logic [IDX_W-1:0]        code_lo,
  output logic [HI_W-1:0]         code_hi,
  output logic                    gs_n
);
  always_comb begin
    code_lo = '0;
    code_hi = '0;
    for (int s = 0; s < STAGES; s++) begin
      code_lo = code_lo | ~code_n_all[s*IDX_W +: IDX_W];
      if (!gs_n_all[s]) code_hi = code_hi | HI_W'(s);
    end
    gs_n = &gs_n_all;
  end
endmodule

// File: rtl/prio_enc_cascade.sv
// Chained priority encoder with registered outputs.
// STAGE_COUNT must be at least 2.
module prio_enc_cascade #(
  parameter int STAGE_BITS  = pe_pkg::PE_STAGE_BITS,
  parameter int STAGE_COUNT = pe_pkg::PE_STAGE_COUNT
) (
  input  logic                                         clk,
  input  logic                                         rst,
  input  logic                                         en_n,
  input  logic [STAGE_COUNT*(1<<STAGE_BITS)-1:0]       req_n,
  output logic [STAGE_BITS+$clog2(STAGE_COUNT)-1:0]    code,
  output logic                                         gs_n,
  output logic                                         eo_n
);
  localparam int STAGE_LINES = 1 << STAGE_BITS;
  localparam int HI_W        = $clog2(STAGE_COUNT);
  localparam int CODE_W      = STAGE_BITS + HI_W;
  localparam int LINES       = STAGE_COUNT * STAGE_LINES;

  // en_chain[STAGE_COUNT] is the block enable; each stage feeds the one below
  logic [STAGE_COUNT:0]              en_chain;
  logic [STAGE_COUNT*STAGE_BITS-1:0] code_n_all;
  logic [STAGE_COUNT-1:0]            gs_n_all;
  logic [STAGE_BITS-1:0]             code_lo;
  logic [HI_W-1:0]                   code_hi;
  logic                              gs_n_comb;

  assign en_chain[STAGE_COUNT] = en_n;

  for (genvar s = 0; s < STAGE_COUNT; s++) begin : g_stage
    pe_stage #(.IDX_W(STAGE_BITS)) u_stage (
      .req_n  (req_n[s*STAGE_LINES +: STAGE_LINES]),
      .en_n   (en_chain[s+1]),
      .code_n (code_n_all[s*STAGE_BITS +: STAGE_BITS]),
      .gs_n   (gs_n_all[s]),
      .eo_n   (en_chain[s])
    );
  end

  pe_merge #(.IDX_W(STAGE_BITS), .STAGES(STAGE_COUNT)) u_merge (
    .code_n_all (code_n_all),
    .gs_n_all   (gs_n_all),
    .code_lo    (code_lo),
    .code_hi    (code_hi),
    .gs_n       (gs_n_comb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      code <= '0;
      gs_n <= pe_pkg::PE_FLAG_IDLE;
      eo_n <= pe_pkg::PE_FLAG_IDLE;
    end else begin
      code <= {code_hi, code_lo};
      gs_n <= gs_n_comb;
      eo_n <= en_chain[0];
    end
  end

  // ---------------- assertions ----------------
  assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    !(!gs_n && !eo_n));

  assert_disabled_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    en_n |=> (gs_n && eo_n && code == '0));

  assert_idle_passdown_R4: assert property (@(posedge clk) disable iff (rst)
    (!en_n && &req_n) |=> (!eo_n && gs_n && code == '0));

  assert_request_group_R5: assert property (@(posedge clk) disable iff (rst)
    (!en_n && !(&req_n)) |=> (!gs_n && eo_n));

  assert_top_line_wins_R2: assert property (@(posedge clk) disable iff (rst)
    (!en_n && !req_n[LINES-1]) |=> (code == {CODE_W{1'b1}}));

  assert_upper_masks_R6: assert property (@(posedge clk) disable iff (rst)
    (!en_n && !(&req_n[LINES-1 -: STAGE_LINES])) |=> (code[CODE_W-1 -: HI_W] == {HI_W{1'b1}}));

  assert_reset_state_R10: assert property (@(posedge clk)
    rst |=> (code == '0 && gs_n && eo_n));
endmodule

// File: tb/prio_enc_cascade_bench.sv
module prio_enc_cascade_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en_n = 1'b1;
  logic [15:0] req_n = '1;
  logic [3:0]  code;
  logic        gs_n, eo_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  prio_enc_cascade u_prio_enc_cascade (
    .clk(clk), .rst(rst), .en_n(en_n), .req_n(req_n),
    .code(code), .gs_n(gs_n), .eo_n(eo_n)
  );

  // reference: {code, gs_n, eo_n}
  function automatic logic [5:0] model(input logic [15:0] r, input logic e);
    logic [3:0] c;
    bit hit;
    c = 4'd0; hit = 1'b0;
    if (e) return {4'd0, 1'b1, 1'b1};
    for (int i = 15; i >= 0; i--) begin
      if (!hit && !r[i]) begin c = 4'(i); hit = 1'b1; end
    end
    if (hit) return {c, 1'b0, 1'b1};
    return {4'd0, 1'b1, 1'b0};
  endfunction

  task automatic compare(input string tag, input logic [5:0] exp);
    logic [5:0] got;
    got = {code, gs_n, eo_n};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s req_n=%h en_n=%b got code=%0d gs_n=%b eo_n=%b exp code=%0d gs_n=%b eo_n=%b",
               tag, req_n, en_n, got[5:2], got[1], got[0], exp[5:2], exp[1], exp[0]);
    end
  endtask

  // drive at falling edge, sample 1 ns after the capturing rising edge
  task automatic apply(input string tag, input logic [15:0] r, input logic e);
    @(negedge clk);
    req_n = r; en_n = e;
    @(posedge clk); #1;
    compare(tag, model(r, e));
  endtask

  task automatic test_reset();
    @(negedge clk); rst = 1'b1; req_n = 16'h0000; en_n = 1'b0;
    @(posedge clk); #1;
    compare("R10 reset", {4'd0, 1'b1, 1'b1});
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic test_idle();
    apply("R4 idle", 16'hFFFF, 1'b0);
    apply("R3 disabled idle", 16'hFFFF, 1'b1);
  endtask

  task automatic test_single_lines();
    for (int i = 0; i < 16; i++) begin
      logic [15:0] r;
      r = ~(16'd1 << i);
      apply((i >= 8) ? "R7 single upper" : "R1 single lower", r, 1'b0);
    end
    apply("R8 line0 only", 16'hFFFE, 1'b0);
  endtask

  task automatic test_lower_sweep();
    for (int e = 0; e < 2; e++) begin
      for (int p = 0; p < 256; p++) begin
        apply(e ? "R3 lower sweep disabled" : "R2 lower sweep", {8'hFF, 8'(p)}, 1'(e));
      end
    end
  endtask

  task automatic test_upper_sweep();
    for (int e = 0; e < 2; e++) begin
      for (int p = 0; p < 256; p++) begin
        logic [7:0] lo;
        lo = 8'(p * 37 + 5);
        apply(e ? "R3 upper sweep disabled" : "R6 upper sweep masks lower", {8'(p), lo}, 1'(e));
      end
    end
  endtask

  task automatic test_cross_group();
    apply("R6 line8 masks line7", 16'hFE7F, 1'b0);
    apply("R5 many requests", 16'h0000, 1'b0);
    apply("R7 line7 lower winner", 16'hFF7F, 1'b0);
    apply("R2 lines 3 and 6", 16'hFFB7, 1'b0);
  endtask

  task automatic test_latency();
    apply("R9 setup", 16'h7FFF, 1'b0);
    @(negedge clk);
    req_n = 16'hFFFE; en_n = 1'b0;
    #1;
    compare("R9 held before edge", {4'd15, 1'b0, 1'b1});
    @(posedge clk); #1;
    compare("R9 updated after edge", {4'd0, 1'b0, 1'b1});
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    test_reset();
    test_idle();
    test_single_lines();
    test_cross_group();
    test_lower_sweep();
    test_upper_sweep();
    test_latency();
    test_reset();
    apply("R4 after mid reset", 16'hFFFF, 1'b0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule